// File: doc/BRIEF.md
# Time-Interval Interpolator Sequencer

This block runs the digital side of an analog time-to-voltage interpolator whose converter is a pipelined ADC that samples without pause on the system clock. When an asynchronous event edge arrives while the block is armed, a set flag turns on the current source that charges the ramp capacitor. The flag crosses into the clock domain through a two-flop synchronizer. A duplicate of the second stage clears the flag, so the charge time equals the synchronizer delay. The capacitor then holds its voltage across the next clock edge, which is the one sample the event owns. The block does not trigger the converter. It counts the converter's pipeline latency and takes the code that belongs to that sample when the code arrives.

The code is joined with a free-running coarse cycle count, latched when the second synchronizer stage rises, to form one timestamp record marked by a one-cycle strobe. The block then shorts the capacitor for a fixed number of cycles and re-arms. Edges that arrive while a sequence is in progress do not start charging and produce no record. They set a sticky overrun flag that only reset clears. Turning codes into time units and calibrating the ramp are done downstream.

Top module: `tvi_sequencer`

## Requirements
- R1: A low `rst_ni` (asynchronous, any time) forces `charge_en_o`, `discharge_o`, `rec_valid_o` and `overrun_o` to 0 and abandons any sequence in progress, so no record follows it.
- R2: In the idle state, a rising edge on `evt_i` raises `charge_en_o` at once. The output is still high just after the first clock edge that follows the event and is low just after the second.
- R3: The coarse counter starts at 0 after reset and adds 1 on every clock edge. The record carries the counter value held between the first and second edges after the event.
- R4: The third clock edge after the event is the sample edge. The code for the sample taken at edge n is presented on `adc_code_i` during the cycle after edge n+LAT. The record carries exactly that code.
- R5: `rec_valid_o` is high for exactly one cycle, starting at edge LAT+4 counted from the event, and each accepted event produces exactly one record.
- R6: `discharge_o` is high for exactly DIS cycles, starting in the same cycle as `rec_valid_o`. An event in the first cycle after it falls is accepted.
- R7: `charge_en_o` and `discharge_o` are never high in the same cycle.
- R8: From the first edge after an accepted event until `discharge_o` falls, a rising edge on `evt_i` leaves `charge_en_o` low and adds no record.
- R9: An edge ignored under R8 sets `overrun_o`, which then stays high until reset. The edge's pulse must be at least two clock periods long, with at least two clock periods before it. Accepted events never set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared with the ADC sampling |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 1 | Asynchronous event to be timestamped (rising edge) |
| adc_code_i | input | CODE_W | Code stream from the free-running pipelined ADC |
| charge_en_o | output | 1 | Enables the ramp capacitor current source |
| discharge_o | output | 1 | Shorts the ramp capacitor |
| rec_valid_o | output | 1 | One-cycle strobe marking a new record |
| rec_coarse_o | output | CNT_W | Coarse cycle count of the record |
| rec_code_o | output | CODE_W | ADC code selected for the record |
| overrun_o | output | 1 | Sticky flag: an event was ignored while busy |

## Verification
The overrun detector and the acceptance path watch the same `evt_i` edge through parallel synchronizers. For an accepted event, both report the edge in the same cycle, and the coincidence must not count as an overrun. The bench places a second pulse in the last discharge cycle, which must be ignored and flagged. It then starts the next event in the first idle cycle, which must yield a full record while the sticky flag only holds its value. A reset issued while the block waits for the pipeline latency checks that a pending capture dies with the sequence.

// File: rtl/tvi_pkg.sv
`timescale 1ns/1ps
package tvi_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_HOLD  = 2'd1,
      ST_WAIT  = 2'd2,
      ST_DISCH = 2'd3
   } tvi_state_e;

   localparam int TAG_COUNTER = 0;
   localparam int TAG_SHIFT   = 1;

endpackage

// File: rtl/tvi_event_sync.sv
`timescale 1ns/1ps
module tvi_event_sync (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic evt_i,
   input  logic arm_i,
   output logic charge_o,
   output logic seen_o,
   output logic detect_o,
   output logic ignored_o
);
   localparam int STAGES = 3;

   logic              flag_q;
   logic              clr_q;
   logic              flag_clr;
   logic [STAGES-1:0] fsync_q;
   logic [STAGES-1:0] rsync_q;

   // flag clear comes from a dedicated flop mirroring the second stage
   assign flag_clr = clr_q | ~rst_ni;

   always_ff @(posedge evt_i or posedge flag_clr) begin
      if (flag_clr) begin
         flag_q <= 1'b0;
      end else if (arm_i) begin
         flag_q <= 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         fsync_q <= '0;
         rsync_q <= '0;
         clr_q   <= 1'b0;
      end else begin
         fsync_q <= {fsync_q[STAGES-2:0], flag_q};
         rsync_q <= {rsync_q[STAGES-2:0], evt_i};
         clr_q   <= fsync_q[0];
      end
   end

   assign charge_o  = flag_q;
   assign seen_o    = fsync_q[0];
   assign detect_o  = fsync_q[1] & ~fsync_q[2];
   // a raw edge that did not arrive together with an accepted flag edge
   assign ignored_o = rsync_q[1] & ~rsync_q[2] & ~detect_o;

endmodule

// File: rtl/tvi_latency_tag.sv
`timescale 1ns/1ps
module tvi_latency_tag #(
   parameter int LAT   = 3,
   parameter int STYLE = 0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic fire_o
);
   import tvi_pkg::*;

   localparam int CW = $clog2(LAT + 1) + 1;

   generate
      if (LAT < 1) begin : g_bad_lat
         $error("tvi_latency_tag: LAT must be at least 1");
      end
      if (STYLE != TAG_COUNTER && STYLE != TAG_SHIFT) begin : g_bad_style
         $error("tvi_latency_tag: unknown STYLE");
      end

      if (STYLE == TAG_SHIFT) begin : g_shift
         logic [LAT:0] sr_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               sr_q <= '0;
            end else begin
               sr_q <= {sr_q[LAT-1:0], start_i};
            end
         end
         assign fire_o = sr_q[LAT];
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         logic          run_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               cnt_q <= '0;
               run_q <= 1'b0;
            end else if (start_i) begin
               cnt_q <= CW'(LAT);
               run_q <= 1'b1;
            end else if (run_q) begin
               if (cnt_q == '0) begin
                  run_q <= 1'b0;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
         end
         assign fire_o = run_q && (cnt_q == '0);
      end
   endgenerate

endmodule

// File: rtl/tvi_ctrl_fsm.sv
`timescale 1ns/1ps
module tvi_ctrl_fsm #(
   parameter int DIS = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              seen_i,
   input  logic              fire_i,
   output tvi_pkg::tvi_state_e state_o,
   output logic              arm_o,
   output logic              latch_o,
   output logic              start_o,
   output logic              capture_o,
   output logic              disch_o
);
   import tvi_pkg::*;

   localparam int DW = $clog2(DIS + 1) + 1;

   generate
      if (DIS < 1) begin : g_bad_dis
         $error("tvi_ctrl_fsm: DIS must be at least 1");
      end
   endgenerate

   tvi_state_e    state_q, state_d;
   logic [DW-1:0] dcnt_q, dcnt_d;

   always_comb begin
      state_d = state_q;
      dcnt_d  = dcnt_q;
      unique case (state_q)
         ST_IDLE: begin
            if (seen_i) state_d = ST_HOLD;
         end
         ST_HOLD: begin
            state_d = ST_WAIT;
         end
         ST_WAIT: begin
            if (fire_i) begin
               state_d = ST_DISCH;
               dcnt_d  = DW'(DIS - 1);
            end
         end
         ST_DISCH: begin
            if (dcnt_q == '0) begin
               state_d = ST_IDLE;
            end else begin
               dcnt_d = dcnt_q - 1'b1;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         dcnt_q  <= '0;
      end else begin
         state_q <= state_d;
         dcnt_q  <= dcnt_d;
      end
   end

   assign state_o   = state_q;
   assign arm_o     = (state_q == ST_IDLE);
   assign latch_o   = (state_q == ST_IDLE) && seen_i;
   assign start_o   = (state_q == ST_HOLD);
   assign capture_o = (state_q == ST_WAIT) && fire_i;
   assign disch_o   = (state_q == ST_DISCH);

endmodule

// File: rtl/tvi_sequencer.sv
`timescale 1ns/1ps
module tvi_sequencer #(
   parameter int CODE_W    = 12,
   parameter int CNT_W     = 16,
   parameter int LAT       = 3,
   parameter int DIS       = 2,
   parameter int TAG_STYLE = 0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              evt_i,
   input  logic [CODE_W-1:0] adc_code_i,
   output logic              charge_en_o,
   output logic              discharge_o,
   output logic              rec_valid_o,
   output logic [CNT_W-1:0]  rec_coarse_o,
   output logic [CODE_W-1:0] rec_code_o,
   output logic              overrun_o
);
   import tvi_pkg::*;

   generate
      if (CODE_W < 1 || CNT_W < 2) begin : g_bad_width
         $error("tvi_sequencer: CODE_W must be >= 1 and CNT_W >= 2");
      end
   endgenerate

   logic       arm, seen, detect, ignored;
   logic       latch, start, capture, disch, fire;
   tvi_state_e state;

   logic [CNT_W-1:0]  coarse_q, coarse_hold_q, rec_coarse_q;
   logic [CODE_W-1:0] rec_code_q;
   logic              valid_q, overrun_q;

   tvi_event_sync u_sync (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_i     (evt_i),
      .arm_i     (arm),
      .charge_o  (charge_en_o),
      .seen_o    (seen),
      .detect_o  (detect),
      .ignored_o (ignored)
   );

   tvi_ctrl_fsm #(.DIS(DIS)) u_fsm (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .seen_i    (seen),
      .fire_i    (fire),
      .state_o   (state),
      .arm_o     (arm),
      .latch_o   (latch),
      .start_o   (start),
      .capture_o (capture),
      .disch_o   (disch)
   );

   tvi_latency_tag #(.LAT(LAT), .STYLE(TAG_STYLE)) u_tag (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start),
      .fire_o  (fire)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         coarse_q      <= '0;
         coarse_hold_q <= '0;
         rec_coarse_q  <= '0;
         rec_code_q    <= '0;
         valid_q       <= 1'b0;
         overrun_q     <= 1'b0;
      end else begin
         coarse_q  <= coarse_q + 1'b1;
         valid_q   <= capture;
         overrun_q <= overrun_q | ignored;
         if (latch) coarse_hold_q <= coarse_q;
         if (capture) begin
            rec_coarse_q <= coarse_hold_q;
            rec_code_q   <= adc_code_i;
         end
      end
   end

   logic unused_ok;
   assign unused_ok = detect ^ (state == ST_HOLD);

   assign discharge_o  = disch;
   assign rec_valid_o  = valid_q;
   assign rec_coarse_o = rec_coarse_q;
   assign rec_code_o   = rec_code_q;
   assign overrun_o    = overrun_q;

endmodule

// File: rtl/tvi_sequencer_chk.sv
`timescale 1ns/1ps
module tvi_sequencer_chk #(
   parameter int DIS = 2
) (
   input logic clk_i,
   input logic rst_ni,
   input logic charge_en_o,
   input logic discharge_o,
   input logic rec_valid_o,
   input logic overrun_o
);
   localparam int RW = $clog2(DIS + 2) + 1;

   logic [RW-1:0] run_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q <= '0;
      end else if (discharge_o) begin
         if (run_q != {RW{1'b1}}) run_q <= run_q + 1'b1;
      end else begin
         run_q <= '0;
      end
   end

   assert_no_overlap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(charge_en_o && discharge_o));

   assert_single_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rec_valid_o |=> !rec_valid_o);

   assert_short_with_record_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(discharge_o) |-> rec_valid_o);

   assert_short_length_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!discharge_o && run_q != '0) |-> (run_q == RW'(DIS)));

   assert_overrun_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      overrun_o |=> overrun_o);

   assert_charge_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (charge_en_o && $past(charge_en_o)) |=> !charge_en_o);

endmodule

bind tvi_sequencer tvi_sequencer_chk #(.DIS(DIS)) u_chk (.*);

// File: tb/tvi_sequencer_test.sv
`timescale 1ns/1ps
module tvi_sequencer_test;
   localparam int CODE_W   = 12;
   localparam int CNT_W    = 16;
   localparam int LAT      = 3;
   localparam int DIS      = 2;
   localparam int BUSY_END = LAT + 3 + DIS;
   localparam int NV       = 9;
   // {gap negedges, event phase ns, ignored-pulse negedge (0 = none)}
   localparam logic [23:0] VEC [NV] = '{
      {8'd3, 8'd0, 8'd0},
      {8'd1, 8'd5, 8'd0},
      {8'd1, 8'd8, 8'd0},
      {8'd6, 8'd2, 8'd0},
      {8'd1, 8'd1, 8'd0},
      {8'd2, 8'd3, 8'd5},
      {8'd1, 8'd0, 8'd8},
      {8'd4, 8'd6, 8'd6},
      {8'd1, 8'd7, 8'd0}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              evt = 1'b0;
   logic [CODE_W-1:0] adc = '0;
   logic              charge, disch, valid, ovr;
   logic [CNT_W-1:0]  coarse;
   logic [CODE_W-1:0] code;

   int cyc = 0;
   int n_chk = 0;
   int n_bad = 0;
   bit exp_ovr = 1'b0;
   bit done = 1'b0;

   tvi_sequencer #(.CODE_W(CODE_W), .CNT_W(CNT_W), .LAT(LAT), .DIS(DIS)) uut (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .evt_i        (evt),
      .adc_code_i   (adc),
      .charge_en_o  (charge),
      .discharge_o  (disch),
      .rec_valid_o  (valid),
      .rec_coarse_o (coarse),
      .rec_code_o   (code),
      .overrun_o    (ovr)
   );

   always #10 clk = ~clk;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   function automatic logic [CODE_W-1:0] code_of(int n);
      return CODE_W'(n * 37 + 11);
   endfunction

   // ADC model: the sample of edge n appears after edge n+LAT
   initial forever begin
      @(negedge clk);
      adc = code_of(cyc - LAT);
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic run_event(input int gap, input int ph, input int extra);
      int c0;
      int last;
      repeat (gap) @(negedge clk);
      c0 = cyc;
      #(ph) evt = 1'b1;
      last = (extra + 4 > BUSY_END) ? extra + 4 : BUSY_END;
      for (int i = 1; i <= last; i++) begin
         bit exp_v, exp_d;
         @(negedge clk);
         if (i == 1) chk(charge == 1'b1, "R2 charge on", 32'(charge), 32'd1);
         if (i >= 2 && i <= BUSY_END) chk(charge == 1'b0, "R2/R8 charge off", 32'(charge), 32'd0);
         exp_v = (i == LAT + 4);
         exp_d = (i >= LAT + 4) && (i <= BUSY_END);
         chk(valid == exp_v, "R5/R8 record strobe", 32'(valid), 32'(exp_v));
         chk(disch == exp_d, "R6 discharge", 32'(disch), 32'(exp_d));
         chk(!(charge && disch), "R7 exclusive", 32'({charge, disch}), 32'd0);
         if (exp_v) begin
            chk(coarse == CNT_W'(c0 + 1), "R3 coarse", 32'(coarse), 32'(CNT_W'(c0 + 1)));
            chk(code == code_of(c0 + 3), "R4 code", 32'(code), 32'(code_of(c0 + 3)));
         end
         if (i == 2) evt = 1'b0;
         if (extra != 0 && i == extra) evt = 1'b1;
         if (extra != 0 && i == extra + 2) evt = 1'b0;
      end
      if (extra != 0) exp_ovr = 1'b1;
      chk(ovr == exp_ovr, "R9 overrun", 32'(ovr), 32'(exp_ovr));
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk({charge, disch, valid, ovr} == 4'b0, "R1 reset state", 32'({charge, disch, valid, ovr}), 32'd0);
      rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         run_event(int'(VEC[v][23:16]), int'(VEC[v][15:8]), int'(VEC[v][7:0]));
      end

      // R1: reset while waiting for the pipeline latency
      @(negedge clk);
      evt = 1'b1;
      repeat (2) @(negedge clk);
      evt = 1'b0;
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk({charge, disch, valid, ovr} == 4'b0, "R1 abort outputs", 32'({charge, disch, valid, ovr}), 32'd0);
      exp_ovr = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         chk(!valid && !disch, "R1 no record after abort", 32'({valid, disch}), 32'd0);
      end

      // restart after reset: counter restarts, overrun cleared
      run_event(1, 4, 0);
      // ignored pulse in last busy cycle, then event on first idle cycle
      run_event(2, 2, BUSY_END);
      run_event(1, 3, 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule